// File: doc/BRIEF.md
# Pipelined Vectoring CORDIC Rectangular-to-Polar Converter

This block turns a stream of signed in-phase/quadrature samples into an envelope magnitude and a phase angle. It accepts one sample on every clock and delivers one result on every clock. A polar transmitter uses it to split each baseband point into the envelope, which drives the amplitude path, and the phase, which drives a phase modulator. The angle is returned as a two's-complement fraction of a half-turn. The most negative code stands for ±π, and the value wraps around modulo a full turn.

The CORDIC iterations are unrolled into a register pipeline. The entry stage needs no shifter. It moves the vector into the right half-plane by exchanging the two coordinates and inverting one of them, and it credits a quarter-turn of phase. The stages after it keep the vertical coordinate pre-multiplied by 2^k. The vertical update then becomes a fixed doubling. The horizontal update uses a constant shift of 2k that is wired into each stage. The last stage multiplies the accumulated horizontal coordinate by the constant CORDIC gain compensation and rounds it to the output width.

Top module: `rect_polar_cordic`

## Requirements
- R1: A sample taken at a rising edge with `in_valid` high yields its result with `out_valid` high exactly ITER+1 rising edges later. The block accepts one sample per clock, and gaps in `in_valid` reappear unchanged at the output with no extra valid cycles.
- R2: `out_mag` is an unsigned DATA_W+1 bit value within ±2 LSB of round(sqrt(x²+y²)).
- R3: `out_phase` is within ±4 LSB, modulo 2^PHASE_W, of atan2(y,x)·2^(PHASE_W−1)/π, for every input whose magnitude is at least 16 LSB.
- R4: Inputs on the axes give fixed codes within the R3 tolerance. Positive x gives 0. Positive y gives +2^(PHASE_W−2). Negative y gives −2^(PHASE_W−2). Negative x gives −2^(PHASE_W−1), which is the same code as +π.
- R5: An input of (0,0) gives a magnitude of 0. Its phase is unspecified.
- R6: Full-scale inputs, including (−2^(DATA_W−1), −2^(DATA_W−1)), give results within tolerance with no internal overflow. The magnitude never exceeds floor(1.415·2^(DATA_W−1))+3.
- R7: While `rst` is high, `out_valid` stays low whatever `in_valid` does. After release it stays low until the first sample accepted after reset comes out.
- R8: The entry stage makes x ≥ 0 for every input. A vector with y ≥ 0 is turned by −90° and credited +2^(PHASE_W−2). A vector with y < 0 is turned by +90° and credited −2^(PHASE_W−2). Inputs in the left half-plane therefore get correct phases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all registers update on the rising edge |
| rst | input | 1 | Synchronous active-high reset of the valid pipeline |
| in_valid | input | 1 | High when `in_x`/`in_y` carry a sample |
| in_x | input | DATA_W | Two's-complement in-phase sample |
| in_y | input | DATA_W | Two's-complement quadrature sample |
| out_valid | output | 1 | High when `out_mag`/`out_phase` carry a result |
| out_mag | output | DATA_W+1 | Unsigned envelope magnitude |
| out_phase | output | PHASE_W | Two's-complement phase, full scale = ±π |

## Verification
Every result is due ITER+1 rising edges after the edge that took its sample: one edge for the fold register, ITER−1 edges for the rotation stages and one edge for the gain register. The bench drives on falling edges and records, for each cycle, whether a sample went in. On each falling edge it compares `out_valid` with the entry made ITER+1 cycles earlier. It pops expected samples in order, so a result that comes one cycle early or late fails R1, and its data is also checked against the wrong sample. The expected magnitude and phase come from real-valued square root and arctangent in the bench, and the phase is compared modulo a full turn.

// File: rtl/r2p_pkg.sv
package r2p_pkg;

    // Angle table resolution: 2^ANG_FRAC corresponds to one half-turn (pi).
    localparam int ANG_FRAC  = 24;
    // Gain compensation: round(0.6072529 * 2^GAIN_FRAC), valid for 8 or more rotations.
    localparam int GAIN_FRAC = 16;
    localparam int GAIN_Q    = 39797;
    // round(2^ANG_FRAC / pi), used for small-angle entries.
    localparam int INV_PI_Q  = 5340354;

    // atan(2^-k) / pi, scaled by 2^ANG_FRAC.
    function automatic int atan_q24(input int k);
        case (k)
            0:       return 4194304;
            1:       return 2476042;
            2:       return 1308273;
            3:       return 664100;
            4:       return 333339;
            5:       return 166832;
            6:       return 83436;
            7:       return 41721;
            default: return ((INV_PI_Q >>> (k - 1)) + 1) >>> 1;
        endcase
    endfunction

    // Same angle rounded to a phase word of phase_w bits (1.0 = pi).
    function automatic int step_angle(input int k, input int phase_w);
        int sh;
        sh = ANG_FRAC - (phase_w - 1);
        return (atan_q24(k) + (1 <<< (sh - 1))) >>> sh;
    endfunction

endpackage

// File: rtl/r2p_fold.sv
module r2p_fold #(
    parameter int DW   = 12,
    parameter int IW   = 20,
    parameter int FRAC = 4,
    parameter int PW   = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 vld_i,
    input  logic [DW-1:0]        x_i,
    input  logic [DW-1:0]        y_i,
    output logic                 vld_o,
    output logic signed [IW-1:0] x_o,
    output logic signed [IW-1:0] y_o,
    output logic [PW-1:0]        z_o
);
    localparam logic [PW-1:0] QUARTER = PW'(1) << (PW - 2);

    logic signed [IW-1:0] xe;
    logic signed [IW-1:0] ye;

    // Sign-extend and append fractional guard bits.
    assign xe = {{(IW - DW){x_i[DW-1]}}, x_i} <<< FRAC;
    assign ye = {{(IW - DW){y_i[DW-1]}}, y_i} <<< FRAC;

    always_ff @(posedge clk) begin
        if (rst) vld_o <= 1'b0;
        else     vld_o <= vld_i;
    end

    // Swap and negate: no shifter, only a quarter-turn credit.
    always_ff @(posedge clk) begin
        if (y_i[DW-1]) begin
            x_o <= -ye;
            y_o <= xe;
            z_o <= -QUARTER;
        end else begin
            x_o <= ye;
            y_o <= -xe;
            z_o <= QUARTER;
        end
    end

    // R8
    fold_halfplane_chk: assert property (@(posedge clk) disable iff (rst)
        vld_o |-> !x_o[IW-1]);

endmodule

// File: rtl/r2p_stage.sv
module r2p_stage
    import r2p_pkg::*;
#(
    parameter int IW = 20,
    parameter int PW = 16,
    parameter int K  = 0
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 vld_i,
    input  logic signed [IW-1:0] x_i,
    input  logic signed [IW-1:0] y_i,
    input  logic [PW-1:0]        z_i,
    output logic                 vld_o,
    output logic signed [IW-1:0] x_o,
    output logic signed [IW-1:0] y_o,
    output logic [PW-1:0]        z_o
);
    localparam int            SHIFT = 2 * K;
    localparam logic [PW-1:0] ANG   = PW'(step_angle(K, PW));

    logic                 neg;
    logic signed [IW-1:0] y_sh;

    assign neg  = y_i[IW-1];
    assign y_sh = y_i >>> SHIFT;

    always_ff @(posedge clk) begin
        if (rst) vld_o <= 1'b0;
        else     vld_o <= vld_i;
    end

    // y is carried pre-scaled by 2^K, so its update is a fixed doubling.
    always_ff @(posedge clk) begin
        if (neg) begin
            x_o <= x_i - y_sh;
            y_o <= (y_i + x_i) <<< 1;
            z_o <= z_i - ANG;
        end else begin
            x_o <= x_i + y_sh;
            y_o <= (y_i - x_i) <<< 1;
            z_o <= z_i + ANG;
        end
    end

    // R2
    x_grow_chk: assert property (@(posedge clk) disable iff (rst)
        vld_o |-> (x_o >= $past(x_i)));

    // R6
    y_range_chk: assert property (@(posedge clk) disable iff (rst)
        vld_o |-> (y_o[IW-1] == y_o[IW-2]));

endmodule

// File: rtl/r2p_gain.sv
module r2p_gain
    import r2p_pkg::*;
#(
    parameter int IW   = 20,
    parameter int FRAC = 4,
    parameter int MW   = 13,
    parameter int PW   = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 vld_i,
    input  logic signed [IW-1:0] x_i,
    input  logic [PW-1:0]        z_i,
    output logic                 vld_o,
    output logic [MW-1:0]        mag_o,
    output logic [PW-1:0]        ph_o
);
    localparam int            PWID    = IW + GAIN_FRAC + 2;
    localparam int            DROP    = GAIN_FRAC + FRAC;
    localparam logic [MW-1:0] MAG_CAP = MW'(((1 << (MW - 2)) * 1449) / 1024 + 3);

    logic signed [PWID-1:0] prod;
    logic signed [PWID-1:0] scaled;

    assign prod   = PWID'(x_i) * PWID'(GAIN_Q);
    assign scaled = (prod + (PWID'(1) <<< (DROP - 1))) >>> DROP;

    always_ff @(posedge clk) begin
        if (rst) vld_o <= 1'b0;
        else     vld_o <= vld_i;
    end

    always_ff @(posedge clk) begin
        mag_o <= scaled[MW-1:0];
        ph_o  <= z_i;
    end

    // R6
    mag_bound_chk: assert property (@(posedge clk) disable iff (rst)
        vld_o |-> (mag_o <= MAG_CAP));

endmodule

// File: rtl/rect_polar_cordic.sv
module rect_polar_cordic #(
    parameter int DATA_W  = 12,
    parameter int PHASE_W = 16,
    parameter int ITER    = 16,
    parameter int FRAC_W  = 4,
    parameter int GUARD_W = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic [DATA_W-1:0]    in_x,
    input  logic [DATA_W-1:0]    in_y,
    output logic                 out_valid,
    output logic [DATA_W:0]      out_mag,
    output logic [PHASE_W-1:0]   out_phase
);
    localparam int IW    = DATA_W + FRAC_W + GUARD_W;
    localparam int MAG_W = DATA_W + 1;

    // Index 0: fold output; index j: output of rotation stage with shift k = j-1.
    logic                 vld_p [ITER];
    logic signed [IW-1:0] x_p   [ITER];
    logic signed [IW-1:0] y_p   [ITER];
    logic [PHASE_W-1:0]   z_p   [ITER];

    r2p_fold #(
        .DW   (DATA_W),
        .IW   (IW),
        .FRAC (FRAC_W),
        .PW   (PHASE_W)
    ) u_fold (
        .clk   (clk),
        .rst   (rst),
        .vld_i (in_valid),
        .x_i   (in_x),
        .y_i   (in_y),
        .vld_o (vld_p[0]),
        .x_o   (x_p[0]),
        .y_o   (y_p[0]),
        .z_o   (z_p[0])
    );

    for (genvar j = 1; j < ITER; j++) begin : g_rot
        r2p_stage #(
            .IW (IW),
            .PW (PHASE_W),
            .K  (j - 1)
        ) u_stage (
            .clk   (clk),
            .rst   (rst),
            .vld_i (vld_p[j-1]),
            .x_i   (x_p[j-1]),
            .y_i   (y_p[j-1]),
            .z_i   (z_p[j-1]),
            .vld_o (vld_p[j]),
            .x_o   (x_p[j]),
            .y_o   (y_p[j]),
            .z_o   (z_p[j])
        );
    end

    r2p_gain #(
        .IW   (IW),
        .FRAC (FRAC_W),
        .MW   (MAG_W),
        .PW   (PHASE_W)
    ) u_gain (
        .clk   (clk),
        .rst   (rst),
        .vld_i (vld_p[ITER-1]),
        .x_i   (x_p[ITER-1]),
        .z_i   (z_p[ITER-1]),
        .vld_o (out_valid),
        .mag_o (out_mag),
        .ph_o  (out_phase)
    );

    // R7
    reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> !out_valid);

endmodule

// File: tb/test_rect_polar_cordic.sv
module test_rect_polar_cordic;
    localparam int  DW   = 12;
    localparam int  PW   = 16;
    localparam int  IT   = 16;
    localparam int  LAT  = IT + 1;
    localparam int  FULL = 1 << PW;
    localparam int  HW   = FULL / 2;
    localparam real PI   = 3.14159265358979;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic [DW-1:0] in_x = '0;
    logic [DW-1:0] in_y = '0;
    logic          out_valid;
    logic [DW:0]   out_mag;
    logic [PW-1:0] out_phase;

    int errors = 0;
    int checks = 0;
    int cyc    = 0;
    int n_in   = 0;
    int n_out  = 0;
    bit vhist [8192];
    int sx    [4096];
    int sy    [4096];

    always #10 clk = ~clk;

    rect_polar_cordic #(
        .DATA_W  (DW),
        .PHASE_W (PW),
        .ITER    (IT)
    ) i_rect_polar_cordic (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_x      (in_x),
        .in_y      (in_y),
        .out_valid (out_valid),
        .out_mag   (out_mag),
        .out_phase (out_phase)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic string phase_tag(input int x, input int y);
        if ((x == -2048 || x == 2047) && (y == -2048 || y == 2047)) return "R6";
        if (x == 0 || y == 0) return "R4";
        if (x < 0) return "R8";
        return "R3";
    endfunction

    function automatic string mag_tag(input int x, input int y);
        if (x == 0 && y == 0) return "R5";
        if ((x == -2048 || x == 2047) && (y == -2048 || y == 2047)) return "R6";
        return "R2";
    endfunction

    task automatic check_out();
        bit  ev;
        int  x, y, me, ma, pe, pa, d;
        real m, pr;
        ev = (cyc >= LAT) ? vhist[cyc - LAT] : 1'b0;
        chk(out_valid == ev, (cyc < LAT) ? "R7" : "R1", "out_valid", int'(out_valid), int'(ev));
        if (out_valid && ev) begin
            x = sx[n_out];
            y = sy[n_out];
            n_out++;
            m  = $sqrt(real'(x * x + y * y));
            me = int'(m);
            ma = int'(out_mag);
            d  = ma - me;
            chk(d <= 2 && d >= -2, mag_tag(x, y), "magnitude", ma, me);
            if (m >= 16.0) begin
                pr = $atan2(real'(y), real'(x)) / PI * real'(HW);
                pe = int'(pr);
                pa = int'($signed(out_phase));
                d  = pa - pe;
                d  = (((d % FULL) + FULL + HW) % FULL) - HW;
                chk(d <= 4 && d >= -4, phase_tag(x, y), "phase", pa, pe);
            end
        end
    endtask

    task automatic step(input bit v, input int x, input int y);
        @(negedge clk);
        check_out();
        in_valid = v;
        in_x     = DW'(x);
        in_y     = DW'(y);
        if (v) begin
            sx[n_in] = x;
            sy[n_in] = y;
            n_in++;
        end
        vhist[cyc] = v;
        cyc++;
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL R1 watchdog: actual=%0d expected=%0d results", n_out, n_in);
        summary();
        $finish;
    end

    initial begin
        int gap;
        // R7: samples offered during reset must never appear
        repeat (2) @(negedge clk);
        in_valid = 1'b1;
        in_x     = DW'(100);
        in_y     = DW'(-50);
        repeat (3) begin
            @(negedge clk);
            chk(out_valid == 1'b0, "R7", "out_valid in reset", int'(out_valid), 0);
        end
        in_valid = 1'b0;
        rst      = 1'b0;

        // R4 axes, R5 zero, R6 full-scale corners, R8 left half-plane
        step(1, 1000, 0);
        step(1, 0, 1000);
        step(1, 0, -1000);
        step(1, -1000, 0);
        step(1, 0, 0);
        step(0, 0, 0);
        step(1, -2048, -2048);
        step(1, 2047, 2047);
        step(1, -2048, 2047);
        step(1, 2047, -2048);
        step(1, -2048, 0);
        step(1, -300, -1);
        step(1, -300, 1);

        // Near-exhaustive grid over the input plane, with valid gaps (R1)
        gap = 0;
        for (int xi = -2048; xi < 2048; xi += 73) begin
            for (int yi = -2048; yi < 2048; yi += 79) begin
                step(1, xi, yi);
                gap++;
                if (gap % 7 == 0) step(0, 0, 0);
            end
        end

        repeat (LAT + 4) step(0, 0, 0);
        chk(n_out == n_in, "R1", "result count", n_out, n_in);
        summary();
        $finish;
    end

endmodule